// File: doc/BRIEF.md
# Prioritised Interrupt Identification Unit

This unit sits beside the registers of an asynchronous serial controller. It collects four interrupt causes: receive line errors, arrival of a received character, the transmit holding register becoming empty, and a change on the modem inputs. Each cause latches a pending flag from a single-cycle event input. A four-bit enable register decides which causes may drive the single active-high interrupt line. The unit also decides which one is reported to the host through an identification byte.

The host-side decoding of addresses and strobes stays outside the unit. It arrives here as one-cycle pulses, one for each clearing access: line status read, receive buffer read, transmit holding write, modem status read and identification read. A level input marks the time during which the identification register is addressed. While that level is high, the reported value holds still, so a read cannot see it change partway through.

Top module: `irq_prio_ident`

## Requirements
- R1: After reset, `irq` is 0, `iir` reads 8'h01, all enables are 0, no cause is pending and the transmit holding register counts as empty.
- R2: `iir[7:3]` is always 0. `iir[0]` is 0 when an enabled cause is pending and 1 when none is. `iir[2:1]` is 11 for line status, 10 for received data, 01 for transmit empty and 00 for modem change. Apart from a freeze, `iir` shows the state of the previous cycle.
- R3: When several enabled causes are pending, the reported one is chosen in the order line status, received data, transmit empty, modem change.
- R4: `irq` is 1 in the cycle after any enabled cause is pending, and 0 otherwise. A pending cause whose enable is 0 stays latched and appears once it is enabled.
- R5: An `err_evt` pulse makes line status pending. An `lsr_rd` pulse clears it.
- R6: An `rxd_evt` pulse makes received data pending. An `rbr_rd` pulse clears it.
- R7: A `thre_evt` pulse makes transmit empty pending. A `thr_wr` pulse clears it. An `iir_rd` pulse while `iir_sel` is 1 clears it only when `iir` currently reports 01.
- R8: An `msr_evt` pulse makes modem change pending. An `msr_rd` pulse clears it.
- R9: While `iir_sel` is 1, `iir` keeps the value it had when `iir_sel` rose.
- R10: `ier_we` loads the enables from `ier_wdata` (bit 0 received data, bit 1 transmit empty, bit 2 line status, bit 3 modem change). Setting bit 1 from 0 while the holding register is empty makes transmit empty pending. `thre_evt` marks the register empty and `thr_wr` marks it full.
- R11: When a setting event and a clearing access for the same cause fall in the same cycle, the cause stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Master reset, active high, synchronous |
| ier_we | input | 1 | Enable register write pulse |
| ier_wdata | input | 4 | Enable bits to load |
| err_evt | input | 1 | Overrun, parity, framing or break detected |
| rxd_evt | input | 1 | Character moved into the receive buffer |
| thre_evt | input | 1 | Holding register emptied into the shifter |
| msr_evt | input | 1 | Modem input change detected |
| lsr_rd | input | 1 | Line status register read |
| rbr_rd | input | 1 | Receive buffer read |
| thr_wr | input | 1 | Transmit holding register write |
| msr_rd | input | 1 | Modem status register read |
| iir_sel | input | 1 | Identification register addressed in a selected access |
| iir_rd | input | 1 | Identification register read strobe |
| iir | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
Every combination of the 16 enable masks with the 16 sets of pending causes is applied. The bench then clears the reported cause, one at a time, until nothing is pending. At each step the expected code is checked, which separates the priority order from the encoding and the effect of each clearing access. Directed sequences add a freeze during which a higher cause arrives, and an identification read while a cause other than transmit empty is reported, which must leave transmit empty pending. They also cover enabling transmit empty with the holding register empty and with it full, and a set and a clear that land in the same cycle.

// File: rtl/irq_prio_ident.sv
module irq_prio_ident #(
  parameter int IDW = 8,
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ier_we,
  input  logic [NSRC-1:0] ier_wdata,
  input  logic            err_evt,
  input  logic            rxd_evt,
  input  logic            thre_evt,
  input  logic            msr_evt,
  input  logic            lsr_rd,
  input  logic            rbr_rd,
  input  logic            thr_wr,
  input  logic            msr_rd,
  input  logic            iir_sel,
  input  logic            iir_rd,
  output logic [IDW-1:0]  iir,
  output logic            irq
);
  localparam int PADW = IDW - 3;
  localparam logic [2:0] ID_LSR  = 3'b110;
  localparam logic [2:0] ID_RDA  = 3'b100;
  localparam logic [2:0] ID_THRE = 3'b010;
  localparam logic [2:0] ID_MSR  = 3'b000;
  localparam logic [2:0] ID_NONE = 3'b001;

  logic [NSRC-1:0] ier_q;
  logic lsr_p, rda_p, thre_p, msr_p, thr_empty;
  logic [2:0] id_q, id_live;
  logic [NSRC-1:0] eff;
  logic thre_arm, thre_ack;

  assign eff      = {msr_p, lsr_p, thre_p, rda_p} & ier_q;
  assign thre_arm = ier_we & ier_wdata[1] & ~ier_q[1] & thr_empty;
  assign thre_ack = iir_rd & iir_sel & (id_q == ID_THRE);
  assign irq      = |eff;
  assign iir      = {{PADW{1'b0}}, id_q};

  always_comb begin
    if (eff[2])      id_live = ID_LSR;
    else if (eff[0]) id_live = ID_RDA;
    else if (eff[1]) id_live = ID_THRE;
    else if (eff[3]) id_live = ID_MSR;
    else             id_live = ID_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ier_q     <= '0;
      lsr_p     <= 1'b0;
      rda_p     <= 1'b0;
      thre_p    <= 1'b0;
      msr_p     <= 1'b0;
      thr_empty <= 1'b1;
      id_q      <= ID_NONE;
    end else begin
      if (ier_we) ier_q <= ier_wdata;
      lsr_p     <= err_evt | (lsr_p & ~lsr_rd);
      rda_p     <= rxd_evt | (rda_p & ~rbr_rd);
      msr_p     <= msr_evt | (msr_p & ~msr_rd);
      thre_p    <= thre_evt | thre_arm | (thre_p & ~thr_wr & ~thre_ack);
      thr_empty <= thre_evt | (thr_empty & ~thr_wr);
      if (!iir_sel) id_q <= id_live;
    end
  end

  // R2
  iir_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !iir_sel |=> (iir[0] == !$past(irq)));

  // R9
  iir_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    iir_sel |=> $stable(iir));

  // R5
  lsr_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (lsr_rd && !err_evt) |=> !lsr_p);

  // R6
  rda_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (rbr_rd && !rxd_evt) |=> !rda_p);

  // R7
  thre_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (thr_wr && !thre_evt && !thre_arm) |=> !thre_p);

  // R8
  msr_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (msr_rd && !msr_evt) |=> !msr_p);

  // R10
  thre_arm_chk: assert property (@(posedge clk) disable iff (rst)
    (ier_we && ier_wdata[1] && !ier_q[1] && thr_empty) |=> (thre_p && irq));
endmodule

// File: tb/sim_irq_prio_ident.sv
module sim_irq_prio_ident;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ier_we = 0, err_evt = 0, rxd_evt = 0, thre_evt = 0, msr_evt = 0;
  logic lsr_rd = 0, rbr_rd = 0, thr_wr = 0, msr_rd = 0, iir_sel = 0, iir_rd = 0;
  logic [3:0] ier_wdata = '0;
  logic [7:0] iir;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_prio_ident u0 (
    .clk(clk), .rst(rst), .ier_we(ier_we), .ier_wdata(ier_wdata),
    .err_evt(err_evt), .rxd_evt(rxd_evt), .thre_evt(thre_evt), .msr_evt(msr_evt),
    .lsr_rd(lsr_rd), .rbr_rd(rbr_rd), .thr_wr(thr_wr), .msr_rd(msr_rd),
    .iir_sel(iir_sel), .iir_rd(iir_rd), .iir(iir), .irq(irq)
  );

  // bits of an active set: 0 rx data, 1 tx empty, 2 line status, 3 modem
  function automatic logic [7:0] exp_id(input logic [3:0] act);
    if (act[2])      return 8'h06;
    else if (act[0]) return 8'h04;
    else if (act[1]) return 8'h02;
    else if (act[3]) return 8'h00;
    else             return 8'h01;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    ier_we = 0; err_evt = 0; rxd_evt = 0; thre_evt = 0; msr_evt = 0;
    lsr_rd = 0; rbr_rd = 0; thr_wr = 0; msr_rd = 0; iir_sel = 0; iir_rd = 0;
  endtask

  task automatic do_reset();
    idle();
    rst = 1; step(); step(); rst = 0;
  endtask

  task automatic chk_iir(input string req, input logic [7:0] exp);
    checks++;
    if (iir !== exp) begin
      fails++;
      $display("FAIL %s iir actual %02h expected %02h", req, iir, exp);
    end
  endtask

  task automatic chk_irq(input string req, input logic exp);
    checks++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s irq actual %0b expected %0b", req, irq, exp);
    end
  endtask

  task automatic ier_write(input logic [3:0] m);
    ier_we = 1; ier_wdata = m; step(); idle();
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    chk_iir("R1", 8'h01);
    chk_irq("R1", 1'b0);

    // R2 R3 R4 R5 R6 R7 R8: sweep of enable masks and pending sets
    for (int m = 0; m < 16; m++) begin
      for (int p = 0; p < 16; p++) begin
        logic [3:0] pend;
        pend = p[3:0];
        do_reset();
        thr_wr = 1; step(); idle();
        ier_we = 1; ier_wdata = m[3:0];
        rxd_evt = pend[0]; thre_evt = pend[1]; err_evt = pend[2]; msr_evt = pend[3];
        step(); idle();
        chk_irq("R4", |(pend & m[3:0]));
        step();
        chk_iir("R3", exp_id(pend & m[3:0]));
        for (int k = 0; k < 4; k++) begin
          logic [7:0] cur;
          cur = exp_id(pend & m[3:0]);
          if (cur != 8'h01) begin
            case (cur)
              8'h06: begin lsr_rd = 1; pend[2] = 0; end
              8'h04: begin rbr_rd = 1; pend[0] = 0; end
              8'h02: begin iir_sel = 1; iir_rd = 1; pend[1] = 0; end
              default: begin msr_rd = 1; pend[3] = 0; end
            endcase
            step(); idle(); step();
            chk_iir("R2", exp_id(pend & m[3:0]));
            chk_irq("R4", |(pend & m[3:0]));
          end
        end
      end
    end

    // R9: freeze while addressed
    do_reset();
    ier_write(4'h5);
    rxd_evt = 1; step(); idle(); step();
    chk_iir("R9", 8'h04);
    iir_sel = 1; err_evt = 1; step(); err_evt = 0;
    chk_irq("R5", 1'b1);
    chk_iir("R9", 8'h04);
    step();
    chk_iir("R9", 8'h04);
    iir_sel = 0; step();
    chk_iir("R9", 8'h06);

    // R7: identification read while another cause is reported
    do_reset();
    thr_wr = 1; step(); idle();
    ier_we = 1; ier_wdata = 4'h3; rxd_evt = 1; thre_evt = 1; step(); idle(); step();
    chk_iir("R7", 8'h04);
    iir_sel = 1; iir_rd = 1; step(); idle(); step();
    rbr_rd = 1; step(); idle(); step();
    chk_iir("R7", 8'h02);
    iir_sel = 1; iir_rd = 1; step(); idle(); step();
    chk_iir("R7", 8'h01);
    chk_irq("R7", 1'b0);

    // R10: enabling transmit empty with the holding register empty, then full
    do_reset();
    ier_write(4'h2);
    chk_irq("R10", 1'b1);
    step();
    chk_iir("R10", 8'h02);
    thr_wr = 1; step(); idle();
    chk_irq("R7", 1'b0);
    ier_write(4'h0);
    ier_write(4'h2);
    chk_irq("R10", 1'b0);
    thre_evt = 1; step(); idle();
    chk_irq("R10", 1'b1);

    // R11: a set and a clear in the same cycle
    do_reset();
    ier_write(4'hF);
    thr_wr = 1; step(); idle();
    err_evt = 1; lsr_rd = 1; step(); idle(); step();
    chk_iir("R11", 8'h06);
    lsr_rd = 1; step(); idle();
    thre_evt = 1; thr_wr = 1; step(); idle(); step();
    chk_iir("R11", 8'h02);

    // R4: a disabled cause stays latched
    do_reset();
    msr_evt = 1; step(); idle();
    chk_irq("R4", 1'b0);
    step();
    chk_iir("R4", 8'h01);
    ier_write(4'h8);
    chk_irq("R8", 1'b1);
    step();
    chk_iir("R4", 8'h00);
    msr_rd = 1; step(); idle(); step();
    chk_iir("R8", 8'h01);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule